// File: doc/BRIEF.md
# Rail Enable Source Selector with Software Override

This block produces the enable signal for each of seven power rails. After reset, every rail simply follows its own external enable pin. A single 8-bit control register, loaded through a simple write strobe with a data byte, can take over all rails at once. The top bit is a global override flag. While it is set, each rail's enable comes only from its own register bit, and the pins are ignored.

The register can always be read back. A normal shutdown request clears the whole register in one cycle. Clearing the override flag this way hands every rail back to its pin, and because those pins are low during shutdown, every rail turns off. A shutdown request that arrives in the same cycle as a write beats the write. The serial bus framing in front of the write strobe, the analog regulation and the sequencing ramps are all outside this block.

Top module: `rail_enable_ctrl`

## Requirements
- R1: Asynchronous active-low reset clears the register to 0x00, so the read value is 0x00 and every rail enable follows its pin.
- R2: A write strobe without a shutdown request loads the 8-bit write data on the clock edge, and the read port shows the new value from the next cycle.
- R3: While register bit 7 is 0, rail enable i equals pin i for every rail, and register bits 6:0 have no effect on the rail enables.
- R4: While register bit 7 is 1, rail enable i equals register bit i (rail i sits at bit i, i = 0..6), and pin changes have no effect.
- R5: While bit 7 is 1, a rail whose register bit is 1 stays enabled with its pin held low.
- R6: A single write that sets bit 7 together with enable bits puts both into effect on the same clock edge.
- R7: A shutdown request clears all eight register bits to 0x00 on the next edge, so the rail enables return to the pins.
- R8: When a shutdown request and a write strobe occur in the same cycle, the register becomes 0x00 and the write data is discarded.
- R9: With neither a write strobe nor a shutdown request, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe for the control register |
| wr_data | input | 8 | Write data: bit 7 is the override flag, bits 6:0 are the rail enables |
| shdn_req | input | 1 | Normal shutdown request; clears the register |
| pin_en | input | 7 | External per-rail enable pins |
| rd_data | output | 8 | Current register value |
| rail_en | output | 7 | Resolved per-rail enable |

## Verification
The clocked properties assume that the write strobe, the write data and the shutdown request are sampled synchronously to the clock and are stable around each edge. They also assume the pins settle before an edge. The bench meets these assumptions by changing every input only at the falling edge, and the per-rail selection checks compare the outputs against the register and the pins in the same cycle. Shutdown and write are driven together on purpose to exercise the priority between them.

// File: rtl/rail_ovr_pkg.sv
package rail_ovr_pkg;
  localparam int unsigned DEF_RAILS = 7;

  // next register value: clear beats load beats hold
  function automatic logic [DEF_RAILS:0] next_ctl(
    input logic                 clr,
    input logic                 ld,
    input logic [DEF_RAILS:0]   din,
    input logic [DEF_RAILS:0]   cur
  );
    logic [DEF_RAILS:0] r;
    if (clr)     r = '0;
    else if (ld) r = din;
    else         r = cur;
    return r;
  endfunction

  // per-rail source choice
  function automatic logic pick_src(
    input logic ovr,
    input logic sw_bit,
    input logic pin_bit
  );
    return ovr ? sw_bit : pin_bit;
  endfunction
endpackage

// File: rtl/rail_wr_decode.sv
module rail_wr_decode #(
  parameter int unsigned NUM_RAILS = rail_ovr_pkg::DEF_RAILS,
  localparam int unsigned REG_W = NUM_RAILS + 1
) (
  input  logic             wr_stb,
  input  logic             shdn_req,
  output logic             load_evt,
  output logic             clear_evt,
  output logic             drop_evt
);
  // a shutdown masks any concurrent write
  assign clear_evt = shdn_req;
  assign load_evt  = wr_stb & ~shdn_req;
  assign drop_evt  = wr_stb & shdn_req;
endmodule

// File: rtl/rail_ctl_reg.sv
module rail_ctl_reg #(
  parameter int unsigned NUM_RAILS = rail_ovr_pkg::DEF_RAILS,
  localparam int unsigned REG_W = NUM_RAILS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic             clear_evt,
  input  logic             drop_evt,
  input  logic [REG_W-1:0] din,
  output logic [REG_W-1:0] q
);
  import rail_ovr_pkg::*;

  logic [REG_W-1:0] q_nxt;

  always_comb begin
    if (clear_evt)     q_nxt = '0;
    else if (load_evt) q_nxt = din;
    else               q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (q == $past(din)));

  p_shdn_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (q == '0));

  p_shdn_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (q == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !clear_evt) |=> $stable(q));
endmodule

// File: rtl/rail_src_mux.sv
module rail_src_mux (
  input  logic ovr,
  input  logic sw_bit,
  input  logic pin_bit,
  output logic en
);
  import rail_ovr_pkg::*;
  assign en = pick_src(ovr, sw_bit, pin_bit);
endmodule

// File: rtl/rail_enable_ctrl.sv
module rail_enable_ctrl #(
  parameter int unsigned NUM_RAILS = rail_ovr_pkg::DEF_RAILS,
  localparam int unsigned REG_W = NUM_RAILS + 1,
  localparam int unsigned MODE_BIT = NUM_RAILS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 shdn_req,
  input  logic [NUM_RAILS-1:0] pin_en,
  output logic [REG_W-1:0]     rd_data,
  output logic [NUM_RAILS-1:0] rail_en
);
  logic             load_evt;
  logic             clear_evt;
  logic             drop_evt;
  logic [REG_W-1:0] ctl_q;
  logic             ovr_mode;

  rail_wr_decode #(.NUM_RAILS(NUM_RAILS)) u_dec (
    .wr_stb    (wr_stb),
    .shdn_req  (shdn_req),
    .load_evt  (load_evt),
    .clear_evt (clear_evt),
    .drop_evt  (drop_evt)
  );

  rail_ctl_reg #(.NUM_RAILS(NUM_RAILS)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .clear_evt (clear_evt),
    .drop_evt  (drop_evt),
    .din       (wr_data),
    .q         (ctl_q)
  );

  assign ovr_mode = ctl_q[MODE_BIT];
  assign rd_data  = ctl_q;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    rail_src_mux u_mux (
      .ovr     (ovr_mode),
      .sw_bit  (ctl_q[g]),
      .pin_bit (pin_en[g]),
      .en      (rail_en[g])
    );
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (rd_data == '0));

  p_pin_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[MODE_BIT] |-> (rail_en == pin_en));

  p_sw_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[MODE_BIT] |-> (rail_en == rd_data[NUM_RAILS-1:0]));

  p_joint_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !shdn_req && wr_data[MODE_BIT]) |=>
      (rail_en == $past(wr_data[NUM_RAILS-1:0])));
endmodule

// File: tb/rail_enable_ctrl_bench.sv
module rail_enable_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       shdn_req = 1'b0;
  logic [6:0] pin_en = 7'h00;
  logic [7:0] rd_data;
  logic [6:0] rail_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rail_enable_ctrl u_rail_enable_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .shdn_req(shdn_req), .pin_en(pin_en), .rd_data(rd_data), .rail_en(rail_en)
  );

  // bench's own model of the expected rails
  function automatic logic [6:0] exp_rails(input logic [7:0] r, input logic [6:0] p);
    return r[7] ? r[6:0] : p;
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk7(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes at the falling edge, release at the next
  task automatic cycle_op(input logic w, input logic [7:0] d, input logic s);
    @(negedge clk);
    wr_stb = w; wr_data = d; shdn_req = s;
    @(negedge clk);
    wr_stb = 1'b0; shdn_req = 1'b0; wr_data = 8'h00;
  endtask

  task automatic t_reset;
    pin_en = 7'h2A;
    #1;
    chk8("R1 reg after reset", rd_data, 8'h00);
    chk7("R1 rails follow pins", rail_en, 7'h2A);
  endtask

  task automatic t_write_readback;
    cycle_op(1'b1, 8'h35, 1'b0);
    chk8("R2 readback", rd_data, 8'h35);
    cycle_op(1'b1, 8'h4C, 1'b0);
    chk8("R2 second readback", rd_data, 8'h4C);
  endtask

  task automatic t_pin_mode;
    // register holds 0x4C, bit 7 low
    pin_en = 7'h11; #1;
    chk7("R3 pins 11", rail_en, exp_rails(8'h4C, 7'h11));
    pin_en = 7'h7F; #1;
    chk7("R3 pins 7F", rail_en, 7'h7F);
    pin_en = 7'h00; #1;
    chk7("R3 pins 00 ignores reg bits", rail_en, 7'h00);
  endtask

  task automatic t_joint_write;
    pin_en = 7'h00;
    cycle_op(1'b1, 8'hA5, 1'b0);
    chk8("R6 reg", rd_data, 8'hA5);
    chk7("R6 rails same edge", rail_en, 7'h25);
  endtask

  task automatic t_sw_mode;
    pin_en = 7'h5A; #1;
    chk7("R4 pins ignored 5A", rail_en, exp_rails(8'hA5, 7'h5A));
    pin_en = 7'h7F; #1;
    chk7("R4 pins ignored 7F", rail_en, 7'h25);
    pin_en = 7'h00; #1;
    chk7("R5 rail on with pin low", rail_en, 7'h25);
  endtask

  task automatic t_hold;
    repeat (3) @(negedge clk);
    chk8("R9 hold", rd_data, 8'hA5);
  endtask

  task automatic t_shutdown;
    pin_en = 7'h00;
    cycle_op(1'b0, 8'h00, 1'b1);
    chk8("R7 cleared", rd_data, 8'h00);
    chk7("R7 rails off", rail_en, 7'h00);
    pin_en = 7'h03; #1;
    chk7("R7 rails back to pins", rail_en, 7'h03);
  endtask

  task automatic t_collision;
    cycle_op(1'b1, 8'hFF, 1'b0);
    chk8("R8 setup", rd_data, 8'hFF);
    cycle_op(1'b1, 8'h9E, 1'b1);
    chk8("R8 shutdown wins", rd_data, 8'h00);
    pin_en = 7'h00; #1;
    chk7("R8 rails off", rail_en, 7'h00);
  endtask

  task automatic t_async_reset;
    cycle_op(1'b1, 8'hC3, 1'b0);
    #2 rst_n = 1'b0; #1;
    chk8("R1 async clear", rd_data, 8'h00);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_write_readback();
    t_pin_mode();
    t_joint_write();
    t_sw_mode();
    t_hold();
    t_shutdown();
    t_collision();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule